// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of lock flags shared by two independent processor ports, called left and right. Either port can address every flag. A port asks for a flag by writing a zero to it. On the next cycle it reads the flag back: an all-zero word means it owns the flag, and an all-one word means the other side holds it. The owner gives the flag back by writing a one.

Each port keeps its own request bit for every flag. A request that loses stays pending. When the owner releases the flag, a pending request from the other side takes it over at the same clock edge. A waiting port can also withdraw its request by writing a one. If both ports ask for a free flag in the same cycle, the left port wins.

The flags carry no meaning of their own. Software decides what each flag guards, and each side may give the same flag a different meaning.

Top module: `dual_sema_bank`

## Requirements
- R1: After reset every flag is free, and a read of any flag from either port returns all ones.
- R2: A write with data bit 0 equal to zero to a free flag makes the writing port its owner at that clock edge. A read of that flag from the owner in the next cycle returns all zeros.
- R3: While one port owns a flag, a read of that flag from the other port returns all ones, even after that port has written a zero to it.
- R4: A write of one from the owner releases the flag. If no request from the other side is pending, both ports then read all ones.
- R5: If the other port has a pending request when the owner releases a flag, that port becomes the owner at the release edge. Its read in the next cycle returns all zeros.
- R6: A port with a pending request cancels it by writing a one to the flag. A later release by the owner then leaves the flag free, and the cancelling port reads all ones.
- R7: If both ports write zero to the same free flag in the same cycle, only the left port becomes the owner. The right request stays pending and is granted when the left port releases the flag.
- R8: The flags are independent. A write to one flag changes neither the state nor the read value of any other flag.
- R9: When a port has select and read strobe high, every bit of its read data equals the addressed flag's value. Otherwise its read data is all zeros.
- R10: A write strobe with select low is ignored and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | 3 | Left port flag address |
| l_wdata | input | 1 | Left port write data (0 requests, 1 releases or cancels) |
| l_rdata | output | 8 | Left port read data, the flag value on every bit |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | 3 | Right port flag address |
| r_wdata | input | 1 | Right port write data (0 requests, 1 releases or cancels) |
| r_rdata | output | 8 | Right port read data, the flag value on every bit |

## Verification
The bench first runs single-port take and release on a flag. This separates a correct grant from a flag that only mirrors the last written value. Contention, where one port holds a flag while the other requests it, shows whether a losing request is held back or leaks into ownership. A release with a request still pending, and the same case after that request is cancelled, tell a correct hand-over apart from a stuck request. Same-cycle collisions on all eight flags and a long stretch of random two-port traffic show that left priority and flag independence hold at every address.

// File: rtl/dual_sema_bank.sv
module dual_sema_bank #(
  parameter int FLAGS = 8,
  parameter int DW = 8,
  localparam int AW = $clog2(FLAGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wdata,
  output logic [DW-1:0] r_rdata
);

  logic [FLAGS-1:0] req_l, req_r, own_l, own_r;
  logic [FLAGS-1:0] req_l_n, req_r_n, own_l_n, own_r_n;

  for (genvar i = 0; i < FLAGS; i++) begin : g_flag
    logic hit_l, hit_r;
    assign hit_l = l_sel & l_wr & (l_addr == AW'(i));
    assign hit_r = r_sel & r_wr & (r_addr == AW'(i));
    assign req_l_n[i] = hit_l ? ~l_wdata : req_l[i];
    assign req_r_n[i] = hit_r ? ~r_wdata : req_r[i];
    // left keeps or takes unless right is a still-requesting owner
    assign own_l_n[i] = req_l_n[i] & (own_l[i] | ~(own_r[i] & req_r_n[i]));
    assign own_r_n[i] = req_r_n[i] & ~own_l_n[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l <= '0;
      req_r <= '0;
      own_l <= '0;
      own_r <= '0;
    end else begin
      req_l <= req_l_n;
      req_r <= req_r_n;
      own_l <= own_l_n;
      own_r <= own_r_n;
    end
  end

  assign l_rdata = (l_sel & l_rd) ? {DW{~own_l[l_addr]}} : '0;
  assign r_rdata = (r_sel & r_rd) ? {DW{~own_r[r_addr]}} : '0;

endmodule

// File: rtl/dual_sema_bank_chk.sv
module dual_sema_bank_chk #(
  parameter int FLAGS = 8,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             l_sel,
  input logic             l_wr,
  input logic [AW-1:0]    l_addr,
  input logic             l_wdata,
  input logic             r_sel,
  input logic             r_wr,
  input logic [AW-1:0]    r_addr,
  input logic             r_wdata,
  input logic [FLAGS-1:0] req_l,
  input logic [FLAGS-1:0] req_r,
  input logic [FLAGS-1:0] own_l,
  input logic [FLAGS-1:0] own_r
);

  logic wl, wr_r;
  assign wl   = l_sel & l_wr;
  assign wr_r = r_sel & r_wr;

  // R3: a flag never has two owners
  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R2: ownership implies a live request from the same side
  assert_owner_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_l & ~req_l) == '0) && ((own_r & ~req_r) == '0));

  assert_left_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wl && l_wdata) |=> !own_l[$past(l_addr)]);

  assert_right_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_r && r_wdata) |=> !own_r[$past(r_addr)]);

  assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wl && l_wdata && own_l[l_addr] && req_r[l_addr] &&
     !(wr_r && r_addr == l_addr)) |=> own_r[$past(l_addr)]);

  assert_left_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wl && wr_r && !l_wdata && !r_wdata && l_addr == r_addr &&
     !own_l[l_addr] && !own_r[l_addr])
    |=> own_l[$past(l_addr)] && !own_r[$past(l_addr)] && req_r[$past(l_addr)]);

  // R10: unselected write strobes leave every flag as it was
  assert_unselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wl && !wr_r) |=> $stable(req_l) && $stable(req_r) && $stable(own_l) && $stable(own_r));

endmodule

bind dual_sema_bank dual_sema_bank_chk #(.FLAGS(FLAGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
  .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
  .req_l(req_l), .req_r(req_r), .own_l(own_l), .own_r(own_r)
);

// File: tb/dual_sema_bank_bench.sv
module dual_sema_bank_bench;
  logic clk = 0, rst_n = 0;
  logic l_sel = 0, l_wr = 0, l_rd = 0, l_wdata = 0;
  logic r_sel = 0, r_wr = 0, r_rd = 0, r_wdata = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_rdata, r_rdata;
  int checks = 0, fails = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  dual_sema_bank u_dual_sema_bank (.*);

  // reference model: holder per flag (0 none, 1 left, 2 right), wish per side
  int holder[8];
  bit wish_l[8], wish_r[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (holder[k]) begin holder[k] = 0; wish_l[k] = 0; wish_r[k] = 0; end
    end else begin
      if (l_sel && l_wr) wish_l[l_addr] = !l_wdata;
      if (r_sel && r_wr) wish_r[r_addr] = !r_wdata;
      foreach (holder[k]) begin
        if (holder[k] == 1 && !wish_l[k]) holder[k] = 0;
        if (holder[k] == 2 && !wish_r[k]) holder[k] = 0;
        if (holder[k] == 0) begin
          if (wish_l[k]) holder[k] = 1;
          else if (wish_r[k]) holder[k] = 2;
        end
      end
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // model comparison on every clock, away from the edge (R9 read format)
  always @(negedge clk) if (rst_n) begin
    check({phase, " R9 left"}, l_rdata,
          (l_sel && l_rd) ? ((holder[l_addr] == 1) ? 8'h00 : 8'hFF) : 8'h00);
    check({phase, " R9 right"}, r_rdata,
          (r_sel && r_rd) ? ((holder[r_addr] == 2) ? 8'h00 : 8'hFF) : 8'h00);
  end

  task automatic idle();
    l_sel = 0; l_wr = 0; l_rd = 0; r_sel = 0; r_wr = 0; r_rd = 0;
  endtask

  task automatic lwrite(logic [2:0] a, logic d);
    l_sel = 1; l_wr = 1; l_addr = a; l_wdata = d;
    @(posedge clk); #1; idle();
  endtask

  task automatic rwrite(logic [2:0] a, logic d);
    r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d;
    @(posedge clk); #1; idle();
  endtask

  task automatic lread(logic [2:0] a, logic [7:0] exp, string tag);
    l_sel = 1; l_rd = 1; l_addr = a; #2;
    check(tag, l_rdata, exp);
    @(posedge clk); #1; idle();
  endtask

  task automatic rread(logic [2:0] a, logic [7:0] exp, string tag);
    r_sel = 1; r_rd = 1; r_addr = a; #2;
    check(tag, r_rdata, exp);
    @(posedge clk); #1; idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    phase = "R1";
    for (int a = 0; a < 8; a++) begin
      lread(3'(a), 8'hFF, "R1 left reset");
      rread(3'(a), 8'hFF, "R1 right reset");
    end
    phase = "R2";
    lwrite(3'd2, 0);
    lread(3'd2, 8'h00, "R2 left owns");
    rread(3'd3, 8'hFF, "R8 neighbour untouched");
    phase = "R3";
    rwrite(3'd2, 0);
    rread(3'd2, 8'hFF, "R3 right blocked");
    lread(3'd2, 8'h00, "R3 left keeps");
    phase = "R5";
    lwrite(3'd2, 1);
    rread(3'd2, 8'h00, "R5 right handed over");
    lread(3'd2, 8'hFF, "R5 left sees taken");
    phase = "R4";
    rwrite(3'd2, 1);
    rread(3'd2, 8'hFF, "R4 right freed");
    lread(3'd2, 8'hFF, "R4 left sees free");
    phase = "R6";
    lwrite(3'd5, 0);
    rwrite(3'd5, 0);
    rwrite(3'd5, 1);
    lwrite(3'd5, 1);
    rread(3'd5, 8'hFF, "R6 cancelled stays free");
    lread(3'd5, 8'hFF, "R6 left free");
    phase = "R10";
    l_sel = 0; l_wr = 1; l_addr = 3'd1; l_wdata = 0;
    @(posedge clk); #1; idle();
    lread(3'd1, 8'hFF, "R10 unselected write");
    phase = "R7";
    for (int a = 0; a < 8; a++) begin
      l_sel = 1; l_wr = 1; l_addr = 3'(a); l_wdata = 0;
      r_sel = 1; r_wr = 1; r_addr = 3'(a); r_wdata = 0;
      @(posedge clk); #1; idle();
      lread(3'(a), 8'h00, "R7 left wins");
      rread(3'(a), 8'hFF, "R7 right waits");
      lwrite(3'(a), 1);
      rread(3'(a), 8'h00, "R7 pending right granted");
      rwrite(3'(a), 1);
    end
    phase = "R8";
    lwrite(3'd0, 0);
    rwrite(3'd7, 0);
    lread(3'd7, 8'hFF, "R8 left flag7");
    rread(3'd0, 8'hFF, "R8 right flag0");
    rread(3'd7, 8'h00, "R8 right flag7");
    lwrite(3'd0, 1);
    rwrite(3'd7, 1);
    phase = "R9";
    l_sel = 1; l_rd = 0; l_addr = 3'd0; #2;
    check("R9 no strobe", l_rdata, 8'h00);
    @(posedge clk); #1; idle();
    phase = "random";
    for (int n = 0; n < 2000; n++) begin
      l_sel = 1'($urandom); l_wr = 1'($urandom); l_rd = 1'($urandom);
      l_addr = 3'($urandom); l_wdata = 1'($urandom);
      r_sel = 1'($urandom); r_wr = 1'($urandom); r_rd = 1'($urandom);
      r_addr = 3'($urandom); r_wdata = 1'($urandom);
      @(posedge clk); #1;
    end
    idle();
    @(posedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule